// File: doc/BRIEF.md
# USB Transmit Serializer with Mode Control

This block is the transmit half of a USB 2.0 transceiver macrocell, on its digital side. A link controller hands it packet bytes through a valid/ready handshake. The block puts a synchronization field on the line and shifts out each byte starting with its least significant bit. In normal mode it also inserts stuffed zeros and applies NRZI. When the controller lowers its valid signal, the block closes the packet with end-of-packet signaling. The result is a two-bit line-drive code and a driver enable. The analog drivers, which are outside this block, turn these into bus levels.

The serial side moves one bit each time a bit-rate strobe is high on a clock edge. The strobe may be high on every clock or only on some of them, so one clock domain can serve both bus speeds. A two-bit mode input can act at any moment. It can take the drivers off the bus and cancel a packet in progress, or it can switch to a raw mode. In raw mode each bit goes straight to a J or K level, with no stuffing and no NRZI.

Top module: `usb_tx_serializer`

## Requirements
- R1: While reset is held and afterwards with no packet, `drive_en` is 0, `tx_ready` is 0 and `line_code` shows J (line codes: 2'b00 SE0, 2'b01 J, 2'b10 K).
- R2: The first SYNC bit is driven at the first clock edge that sees `tx_valid` high together with `bit_en` in a driving mode. With `bit_en` held high, `drive_en` is 1 and `line_code` is K one clock after `tx_valid` is raised.
- R3: The SYNC field is seven 0 bits and then a 1. Starting from idle J, it is driven in normal mode as K J K J K J K K.
- R4: `tx_ready` is high during SYNC and data while the holding register is empty. A clock edge with both `tx_valid` and `tx_ready` high loads `tx_data`. `tx_ready` then stays low until that byte moves into the shifter, and every presented byte is sent exactly once.
- R5: In normal mode (`op_mode` 2'b00), bytes go out least significant bit first with NRZI: a 1 keeps the previous level and a 0 toggles between J and K.
- R6: In normal mode, after six consecutive 1 bits a 0 bit is inserted. The final 1 of SYNC counts toward the run, and the inserted bit is still sent when the sixth 1 is the last data bit.
- R7: Once `tx_valid` is low and the last data bit (and any stuffed bit) has gone out, the next strobes drive SE0, SE0 and then J. On the strobe after that, `drive_en` drops and `tx_ready` stays low.
- R8: In raw mode (`op_mode` 2'b10), each bit, the SYNC bits included, is driven directly: 1 as J and 0 as K. No bit is inserted. End-of-packet is the same as in R7.
- R9: In non-driving mode (`op_mode` 2'b01), `drive_en` is 0 in that same cycle and `tx_ready` is 0. A packet in progress is abandoned and does not resume when the mode returns to normal.
- R10: The reserved mode 2'b11 behaves exactly like the non-driving mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-rate strobe; one line bit per high cycle |
| op_mode | input | 2 | 00 normal, 01 non-driving, 10 raw, 11 reserved (non-driving) |
| tx_valid | input | 1 | Controller has a packet byte on `tx_data` |
| tx_data | input | 8 | Byte to transmit |
| tx_ready | output | 1 | Holding register can take a byte this edge |
| line_code | output | 2 | Line drive code: 00 SE0, 01 J, 10 K |
| drive_en | output | 1 | Driver output enable |

## Verification
All line results are registered. A strobe edge updates `line_code` and `drive_en`, so the bench samples them at the falling edge after each cycle in which it drove `bit_en` high. Samples are compared in order against a code list that bench functions build from the SYNC, stuffing, NRZI, raw and end-of-packet rules. The SYNC start is checked for the one-clock latency with the strobe held high. A load is counted when `tx_ready` and `tx_valid` were both high before an edge, and the next byte is presented at the falling edge after it. The turn-off in the non-driving modes is checked shortly after the mode change in that same cycle, since it needs no clock edge. The check that the packet does not resume is made several strobes later.

// File: rtl/usb_tx_serializer.sv
module usb_tx_serializer (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic [1:0] op_mode,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  output logic       tx_ready,
  output logic [1:0] line_code,
  output logic       drive_en
);

  localparam logic [1:0] LC_SE0 = 2'b00;
  localparam logic [1:0] LC_J   = 2'b01;
  localparam logic [1:0] LC_K   = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_SYNC, S_DATA, S_EOP} st_t;

  st_t        state, nstate;
  logic [3:0] cnt, ncnt;
  logic [7:0] hold, shreg;
  logic       hold_full;
  logic [2:0] ones;
  logic       lvl, nlvl;
  logic       oe_q;
  logic [1:0] code_q;
  logic       emit, bitv, load_sh, stuff, se0, jforce, drop;

  wire quiet = op_mode[0];
  wire raw   = (op_mode == 2'b10);

  assign tx_ready  = !quiet && !hold_full && (state == S_SYNC || state == S_DATA);
  assign drive_en  = oe_q && !quiet;
  assign line_code = code_q;
  assign nlvl      = raw ? bitv : (bitv ? lvl : !lvl);

  always_comb begin
    emit = 1'b0; bitv = 1'b0; load_sh = 1'b0; stuff = 1'b0;
    se0 = 1'b0; jforce = 1'b0; drop = 1'b0;
    nstate = state; ncnt = cnt;
    case (state)
      S_IDLE: if (tx_valid) begin
        emit = 1'b1; nstate = S_SYNC; ncnt = 4'd1;
      end
      S_SYNC: begin
        emit = 1'b1;
        bitv = (cnt == 4'd7);
        if (cnt == 4'd7) begin nstate = S_DATA; ncnt = 4'd0; end
        else ncnt = cnt + 4'd1;
      end
      S_DATA: begin
        if (!raw && ones == 3'd6) begin
          emit = 1'b1; stuff = 1'b1;
        end else if (cnt != 4'd0) begin
          emit = 1'b1; bitv = shreg[0]; ncnt = cnt - 4'd1;
        end else if (hold_full) begin
          emit = 1'b1; bitv = hold[0]; load_sh = 1'b1; ncnt = 4'd7;
        end else begin
          se0 = 1'b1; nstate = S_EOP; ncnt = 4'd1;
        end
      end
      default: begin
        if (cnt == 4'd1) begin se0 = 1'b1; ncnt = 4'd2; end
        else if (cnt == 4'd2) begin jforce = 1'b1; ncnt = 4'd3; end
        else begin drop = 1'b1; nstate = S_IDLE; ncnt = 4'd0; end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; cnt <= 4'd0; hold <= 8'd0; shreg <= 8'd0;
      hold_full <= 1'b0; ones <= 3'd0; lvl <= 1'b1; oe_q <= 1'b0; code_q <= LC_J;
    end else if (quiet) begin
      state <= S_IDLE; cnt <= 4'd0; hold_full <= 1'b0;
      ones <= 3'd0; lvl <= 1'b1; oe_q <= 1'b0; code_q <= LC_J;
    end else begin
      if (tx_ready && tx_valid) begin
        hold <= tx_data; hold_full <= 1'b1;
      end
      if (bit_en) begin
        state <= nstate;
        cnt   <= ncnt;
        if (load_sh) begin
          shreg <= hold >> 1; hold_full <= 1'b0;
        end else if (emit && state == S_DATA && !stuff) begin
          shreg <= shreg >> 1;
        end
        if (emit) begin
          lvl    <= nlvl;
          code_q <= nlvl ? LC_J : LC_K;
          oe_q   <= 1'b1;
          ones   <= (raw || !bitv) ? 3'd0 : ones + 3'd1;
        end
        if (se0) code_q <= LC_SE0;
        if (jforce) begin code_q <= LC_J; lvl <= 1'b1; end
        if (drop) begin oe_q <= 1'b0; code_q <= LC_J; ones <= 3'd0; end
      end
    end
  end

endmodule

// File: rtl/usb_tx_serializer_chk.sv
module usb_tx_serializer_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] op_mode,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [1:0] line_code,
  input logic [1:0] st,
  input logic       oe_q,
  input logic [2:0] ones
);

  a_r9_quiet_returns_idle: assert property (@(posedge clk) disable iff (rst)
    op_mode[0] |=> (st == 2'd0));

  a_r10_reserved_not_ready: assert property (@(posedge clk) disable iff (rst)
    (op_mode == 2'b11) |=> !tx_ready);

  a_r4_ready_drops_after_load: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_ready);

  a_r1_idle_undriven: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd0) |-> !oe_q);

  a_r6_run_bounded: assert property (@(posedge clk) disable iff (rst)
    ones <= 3'd6);

  a_r7_se0_only_in_eop: assert property (@(posedge clk) disable iff (rst)
    (oe_q && st != 2'd3) |-> (line_code != 2'b00));

endmodule

bind usb_tx_serializer usb_tx_serializer_chk i_chk (
  .clk(clk), .rst(rst), .op_mode(op_mode), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .line_code(line_code), .st(state),
  .oe_q(oe_q), .ones(ones)
);

// File: tb/test_usb_tx_serializer.sv
module test_usb_tx_serializer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic [1:0] op_mode = 2'b00;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'd0;
  logic       tx_ready;
  logic [1:0] line_code;
  logic       drive_en;

  int checks = 0;
  int errors = 0;

  logic [7:0] pkt [0:15];
  logic [1:0] exp_c [0:511];
  logic [1:0] got_c [0:511];
  int exp_n, got_n, first_cyc, consumed;

  usb_tx_serializer i_usb_tx_serializer (
    .clk(clk), .rst(rst), .bit_en(bit_en), .op_mode(op_mode),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .line_code(line_code), .drive_en(drive_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // expected-code model
  bit m_lvl; int m_ones;
  task automatic push_bit(input bit b, input bit rawm);
    if (rawm) m_lvl = b;
    else if (!b) m_lvl = !m_lvl;
    exp_c[exp_n] = m_lvl ? 2'b01 : 2'b10;
    exp_n++;
  endtask
  task automatic emit_bit(input bit b, input bit rawm);
    push_bit(b, rawm);
    if (!rawm) begin
      if (b) m_ones++; else m_ones = 0;
      if (m_ones == 6) begin push_bit(1'b0, rawm); m_ones = 0; end
    end
  endtask
  task automatic build_expected(input int n, input bit rawm);
    exp_n = 0; m_lvl = 1'b1; m_ones = 0;
    for (int i = 0; i < 8; i++) emit_bit(i == 7, rawm);
    for (int k = 0; k < n; k++)
      for (int b = 0; b < 8; b++) emit_bit(pkt[k][b], rawm);
    exp_c[exp_n] = 2'b00; exp_c[exp_n+1] = 2'b00; exp_c[exp_n+2] = 2'b01;
    exp_n += 3;
  endtask

  task automatic run_packet(input int n, input logic [1:0] mode, input int prob);
    bit en_last, pend, started, done;
    int idx;
    @(negedge clk);
    op_mode = mode;
    tx_valid = 1'b1; tx_data = pkt[0]; idx = 0;
    en_last = ($urandom % 100) < prob;
    bit_en = en_last;
    pend = 1'b0; started = 1'b0; done = 1'b0; got_n = 0; first_cyc = -1;
    for (int cyc = 1; cyc < 3000 && !done; cyc++) begin
      @(negedge clk);
      if (en_last) begin
        if (drive_en) begin
          if (!started) first_cyc = cyc;
          if (got_n < 512) got_c[got_n] = line_code;
          got_n++; started = 1'b1;
        end else if (started) done = 1'b1;
      end
      if (pend) begin
        idx++;
        if (idx < n) tx_data = pkt[idx]; else tx_valid = 1'b0;
      end
      pend = tx_valid && tx_ready;
      en_last = ($urandom % 100) < prob;
      bit_en = en_last;
    end
    consumed = idx;
    bit_en = 1'b0;
    if (!done) chk(1'b0, "watchdog packet", got_n, exp_n);
  endtask

  task automatic compare(input string req);
    int bad;
    bad = -1;
    chk(got_n == exp_n, {req, " length"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (bad < 0 && got_c[i] !== exp_c[i]) bad = i;
    if (bad >= 0) chk(1'b0, {req, " code"}, got_c[bad], exp_c[bad]);
    else chk(1'b1, req, 0, 0);
  endtask

  task automatic abort_case(input logic [1:0] qmode, input string req);
    pkt[0] = 8'hA5; pkt[1] = 8'h3C; pkt[2] = 8'h81;
    @(negedge clk);
    op_mode = 2'b00; bit_en = 1'b1; tx_valid = 1'b1; tx_data = pkt[0];
    repeat (12) @(negedge clk);
    chk(drive_en === 1'b1, {req, " driving before abort"}, drive_en, 1);
    op_mode = qmode;
    #1;
    chk(drive_en === 1'b0, {req, " drive_en off at once"}, drive_en, 0);
    chk(tx_ready === 1'b0, {req, " tx_ready off"}, tx_ready, 0);
    tx_valid = 1'b0;
    repeat (2) @(negedge clk);
    op_mode = 2'b00;
    repeat (4) @(negedge clk);
    chk(drive_en === 1'b0, {req, " no resume"}, drive_en, 0);
    chk(tx_ready === 1'b0, {req, " no resume ready"}, tx_ready, 0);
    chk(line_code === 2'b01, {req, " idle J"}, line_code, 1);
    bit_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(drive_en === 1'b0, "R1 reset drive_en", drive_en, 0);
    chk(tx_ready === 1'b0, "R1 reset tx_ready", tx_ready, 0);
    chk(line_code === 2'b01, "R1 reset line J", line_code, 1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(drive_en === 1'b0 && line_code === 2'b01, "R1 idle after reset", drive_en, 0);

    // R2 R3 R5: latency and pattern, strobe every clock
    pkt[0] = 8'h5A; pkt[1] = 8'h00;
    build_expected(2, 1'b0);
    run_packet(2, 2'b00, 100);
    chk(first_cyc == 1, "R2 SYNC start latency", first_cyc, 1);
    chk(got_c[0] == 2'b10 && got_c[1] == 2'b01 && got_c[6] == 2'b10 && got_c[7] == 2'b10,
        "R3 SYNC pattern", got_c[7], 2);
    chk(consumed == 2, "R4 bytes consumed", consumed, 2);
    compare("R5 normal encode");
    chk(got_c[got_n-1] == 2'b01 && got_c[got_n-2] == 2'b00 && got_c[got_n-3] == 2'b00,
        "R7 EOP tail", got_c[got_n-3], 0);
    chk(drive_en === 1'b0 && tx_ready === 1'b0, "R7 idle after EOP", drive_en, 0);

    // R6: run of ones and stuff after last bit
    pkt[0] = 8'hFF; pkt[1] = 8'hFC;
    build_expected(2, 1'b0);
    run_packet(2, 2'b00, 60);
    chk(exp_n == 8 + 16 + 2 + 3, "R6 model stuff count", exp_n, 29);
    compare("R6 stuffing");

    // R8: raw mode
    pkt[0] = 8'hFF; pkt[1] = 8'h0F; pkt[2] = 8'hC3;
    build_expected(3, 1'b1);
    run_packet(3, 2'b10, 80);
    chk(got_c[0] == 2'b10 && got_c[7] == 2'b01, "R8 raw SYNC", got_c[0], 2);
    compare("R8 raw mode");

    // R9: non-driving holds off a new packet
    @(negedge clk);
    op_mode = 2'b01; bit_en = 1'b1; tx_valid = 1'b1; tx_data = 8'h11;
    repeat (5) @(negedge clk);
    chk(drive_en === 1'b0 && tx_ready === 1'b0, "R9 no start when non-driving", drive_en, 0);
    tx_valid = 1'b0; op_mode = 2'b00;
    abort_case(2'b01, "R9");
    abort_case(2'b11, "R10");

    // random packets, R4 R5 R6 R8
    for (int p = 0; p < 10; p++) begin
      int n;
      bit rawm;
      n = 1 + ($urandom % 8);
      rawm = ($urandom % 3) == 0;
      for (int k = 0; k < n; k++) pkt[k] = ($urandom % 2) ? 8'hFF : 8'($urandom);
      build_expected(n, rawm);
      run_packet(n, rawm ? 2'b10 : 2'b00, 30 + ($urandom % 71));
      chk(consumed == n, "R4 random bytes consumed", consumed, n);
      compare(rawm ? "R8 random raw" : "R6 random normal");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule